// File: doc/BRIEF.md
# Streaming Command Frame Parser

This block sits behind a UART receiver and turns a raw byte stream into command frames. It accepts one byte on each cycle in which the receive strobe is high. It searches the stream for a fixed start byte and then reads the frame in order: a length byte, two command bytes, the payload and a trailing check byte. While the frame arrives, the block folds every byte after the start byte into a running XOR. It releases the frame only if that XOR equals the check byte.

For each accepted frame, the block raises a one-cycle valid pulse. At the same time it presents the two command bytes, the payload length, the message class taken from the upper nibble of the first command byte, and the subsystem taken from the lower nibble. The payload stays readable through an address/data port. Frames with a bad length, a bad check byte or a stalled transfer are dropped. Each kind of drop raises its own pulse, and every drop is counted in a saturating error counter. A downstream dispatcher watches the valid pulse, reads the payload and acts on the command.

The state machine has six states:

- `ST_HUNT` waits for the start byte and moves to `ST_LEN` when it sees it.
- `ST_LEN` moves to `ST_CMD0` when the length is legal, or back to `ST_HUNT` when it is not.
- `ST_CMD0` moves to `ST_CMD1`.
- `ST_CMD1` moves to `ST_DATA`, or straight to `ST_FCS` when the length is zero.
- `ST_DATA` moves to `ST_FCS` after the last payload byte.
- `ST_FCS` always returns to `ST_HUNT`.

An idle-timeout abort sends any state other than `ST_HUNT` back to `ST_HUNT`.

Top module: `cmd_frame_parser`

## Requirements
- R1: While hunting, every byte other than 0xFE is discarded, and no valid or error pulse results from it.
- R2: A frame is the sequence 0xFE, length L, command byte A, command byte B, L payload bytes, check byte. One cycle after the check byte is taken, frame_valid pulses and frame_cmd0=A, frame_cmd1=B and frame_len=L. These outputs hold their values until the next accepted frame.
- R3: frame_valid is high for exactly one cycle per accepted frame.
- R4: A length byte greater than MAX_LEN (default 250) raises len_err for one cycle and returns the parser to hunting with no frame delivered. A length equal to MAX_LEN is accepted.
- R5: If the XOR of the length, both command bytes and all payload bytes differs from the check byte, fcs_err pulses for one cycle and frame_valid stays low.
- R6: frame_type encodes the upper nibble of frame_cmd0 as follows: 0x2 gives 2'd1 (synchronous request), 0x4 gives 2'd2 (asynchronous message), 0x6 gives 2'd3 (synchronous response), and any other value gives 2'd0.
- R7: frame_subsys encodes the lower nibble of frame_cmd0 as follows: 0x1 gives 3'd1 (system), 0x4 gives 3'd2 (application framework), 0x5 gives 3'd3 (device object), 0xF gives 3'd4 (application configuration), and any other value gives 3'd0.
- R8: A frame whose upper nibble is not 0x2, 0x4 or 0x6 is still delivered when its check byte is good, with type_unknown=1. Otherwise type_unknown=0.
- R9: A 0xFE byte in the command, payload or check position is taken as data and does not restart the frame.
- R10: rd_data returns payload byte number rd_addr (counting from 0) of the last delivered frame, from the cycle of its valid pulse until the next frame's payload starts arriving. A zero-length frame is delivered with frame_len=0.
- R11: err_count rises by one in the cycle after each len_err, fcs_err or tmo_err pulse, and holds at its all-ones value once it gets there.
- R12: After TIMEOUT_CYC consecutive cycles without a byte inside a partial frame, tmo_err pulses, the partial frame is dropped and the parser resumes hunting. Shorter gaps between bytes are tolerated.
- R13: After reset, frame_valid, len_err, fcs_err, tmo_err and err_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe from the UART receiver |
| rx_data | input | 8 | Received byte |
| frame_valid | output | 1 | One-cycle pulse for an accepted frame |
| frame_cmd0 | output | 8 | First command byte of the last accepted frame |
| frame_cmd1 | output | 8 | Second command byte of the last accepted frame |
| frame_len | output | 8 | Payload length of the last accepted frame |
| frame_type | output | 2 | Decoded message class |
| frame_subsys | output | 3 | Decoded subsystem |
| type_unknown | output | 1 | Message-class nibble not recognised |
| rd_addr | input | ADDR_W | Payload read index |
| rd_data | output | 8 | Payload byte at rd_addr |
| len_err | output | 1 | Pulse for an over-long length byte |
| fcs_err | output | 1 | Pulse for a check-byte mismatch |
| tmo_err | output | 1 | Pulse for a partial frame that timed out |
| err_count | output | ERR_CNT_W | Saturating count of dropped frames |

## Verification
The bound checker watches the following on every cycle:

- frame_valid lasts exactly one cycle.
- No accepted frame ever carries a length above the limit.
- At most one of the valid and error pulses is high in any cycle.
- The delivered command and length fields stay stable between valid pulses.
- The error counter steps by one after each error pulse and holds once saturated.
- A timeout pulse only follows an idle cycle.

Only the bench scenarios can show the rest:

- The exact XOR acceptance rule.
- The type and subsystem encodings.
- Delivery of unknown-class frames.
- 0xFE taken as data inside a frame.
- The payload contents read back through the read port.
- Gaps just under the timeout being tolerated.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_LEN,
        ST_CMD0,
        ST_CMD1,
        ST_DATA,
        ST_FCS
    } cfp_state_e;

    typedef enum logic [1:0] {
        KIND_UNKNOWN = 2'd0,
        KIND_SREQ    = 2'd1,
        KIND_AREQ    = 2'd2,
        KIND_SRSP    = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        SUB_OTHER  = 3'd0,
        SUB_SYSTEM = 3'd1,
        SUB_APPFW  = 3'd2,
        SUB_DEVOBJ = 3'd3,
        SUB_APPCFG = 3'd4
    } subsys_e;

    function automatic msg_kind_e decode_kind(input logic [3:0] nib);
        unique case (nib)
            4'h2:    return KIND_SREQ;
            4'h4:    return KIND_AREQ;
            4'h6:    return KIND_SRSP;
            default: return KIND_UNKNOWN;
        endcase
    endfunction

    function automatic subsys_e decode_subsys(input logic [3:0] nib);
        unique case (nib)
            4'h1:    return SUB_SYSTEM;
            4'h4:    return SUB_APPFW;
            4'h5:    return SUB_DEVOBJ;
            4'hF:    return SUB_APPCFG;
            default: return SUB_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/cfp_payload_buf.sv
module cfp_payload_buf #(
    parameter int DEPTH  = 250,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        if (32'(rd_addr) < DEPTH) begin
            rd_data = mem[rd_addr];
        end else begin
            rd_data = 8'h00;
        end
    end

endmodule

// File: rtl/cfp_idle_timer.sv
module cfp_idle_timer #(
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic rx_valid,
    output logic expire
);

    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] idle_cnt;

    assign expire = active && !rx_valid && (idle_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!active || rx_valid || expire) begin
            idle_cnt <= '0;
        end else begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/cfp_err_counter.sv
module cfp_err_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cfp_fsm.sv
module cfp_fsm
    import cfp_pkg::*;
#(
    parameter int          MAX_LEN  = 250,
    parameter logic [7:0]  SOF_BYTE = 8'hFE,
    parameter int          ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              tmo_expire,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              frm_valid,
    output logic [7:0]        frm_cmd0,
    output logic [7:0]        frm_cmd1,
    output logic [7:0]        frm_len,
    output logic              len_err,
    output logic              fcs_err,
    output logic              tmo_err
);

    localparam logic [7:0] LEN_LIMIT = 8'(MAX_LEN);

    cfp_state_e state, state_n;
    logic [7:0] cur_len;
    logic [7:0] cur_cmd0;
    logic [7:0] cur_cmd1;
    logic [7:0] run_xor;
    logic [7:0] idx;
    logic       len_bad;
    logic       last_data;

    assign len_bad   = rx_data > LEN_LIMIT;
    assign last_data = idx == (cur_len - 8'd1);
    assign busy      = state != ST_HUNT;
    assign wr_en     = (state == ST_DATA) && rx_valid;
    assign wr_addr   = idx[ADDR_W-1:0];
    assign wr_data   = rx_data;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT: if (rx_valid && rx_data == SOF_BYTE) state_n = ST_LEN;
            ST_LEN:  if (rx_valid) state_n = len_bad ? ST_HUNT : ST_CMD0;
            ST_CMD0: if (rx_valid) state_n = ST_CMD1;
            ST_CMD1: if (rx_valid) state_n = (cur_len == 8'd0) ? ST_FCS : ST_DATA;
            ST_DATA: if (rx_valid && last_data) state_n = ST_FCS;
            ST_FCS:  if (rx_valid) state_n = ST_HUNT;
            default: state_n = ST_HUNT;
        endcase
        if (tmo_expire) begin
            state_n = ST_HUNT;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_n;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_len   <= '0;
            cur_cmd0  <= '0;
            cur_cmd1  <= '0;
            run_xor   <= '0;
            idx       <= '0;
            frm_valid <= 1'b0;
            frm_cmd0  <= '0;
            frm_cmd1  <= '0;
            frm_len   <= '0;
            len_err   <= 1'b0;
            fcs_err   <= 1'b0;
            tmo_err   <= 1'b0;
        end else begin
            frm_valid <= 1'b0;
            len_err   <= 1'b0;
            fcs_err   <= 1'b0;
            tmo_err   <= tmo_expire;
            if (rx_valid) begin
                unique case (state)
                    ST_HUNT: begin
                        idx <= '0;
                    end
                    ST_LEN: begin
                        if (len_bad) begin
                            len_err <= 1'b1;
                        end else begin
                            cur_len <= rx_data;
                            run_xor <= rx_data;
                        end
                    end
                    ST_CMD0: begin
                        cur_cmd0 <= rx_data;
                        run_xor  <= run_xor ^ rx_data;
                    end
                    ST_CMD1: begin
                        cur_cmd1 <= rx_data;
                        run_xor  <= run_xor ^ rx_data;
                        idx      <= '0;
                    end
                    ST_DATA: begin
                        run_xor <= run_xor ^ rx_data;
                        idx     <= idx + 8'd1;
                    end
                    ST_FCS: begin
                        if (run_xor == rx_data) begin
                            frm_valid <= 1'b1;
                            frm_cmd0  <= cur_cmd0;
                            frm_cmd1  <= cur_cmd1;
                            frm_len   <= cur_len;
                        end else begin
                            fcs_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser
    import cfp_pkg::*;
#(
    parameter int         MAX_LEN     = 250,
    parameter logic [7:0] SOF_BYTE    = 8'hFE,
    parameter int         TIMEOUT_CYC = 100000,
    parameter int         ERR_CNT_W   = 8,
    localparam int        ADDR_W      = $clog2(MAX_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    output logic                 frame_valid,
    output logic [7:0]           frame_cmd0,
    output logic [7:0]           frame_cmd1,
    output logic [7:0]           frame_len,
    output logic [1:0]           frame_type,
    output logic [2:0]           frame_subsys,
    output logic                 type_unknown,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [7:0]           rd_data,
    output logic                 len_err,
    output logic                 fcs_err,
    output logic                 tmo_err,
    output logic [ERR_CNT_W-1:0] err_count
);

    logic              busy;
    logic              tmo_expire;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    msg_kind_e         kind;

    cfp_fsm #(
        .MAX_LEN  (MAX_LEN),
        .SOF_BYTE (SOF_BYTE),
        .ADDR_W   (ADDR_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tmo_expire (tmo_expire),
        .busy       (busy),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frm_valid  (frame_valid),
        .frm_cmd0   (frame_cmd0),
        .frm_cmd1   (frame_cmd1),
        .frm_len    (frame_len),
        .len_err    (len_err),
        .fcs_err    (fcs_err),
        .tmo_err    (tmo_err)
    );

    cfp_payload_buf #(
        .DEPTH  (MAX_LEN),
        .ADDR_W (ADDR_W)
    ) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    generate
        if (TIMEOUT_CYC > 0) begin : g_tmo
            cfp_idle_timer #(
                .TIMEOUT_CYC (TIMEOUT_CYC)
            ) u_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .active   (busy),
                .rx_valid (rx_valid),
                .expire   (tmo_expire)
            );
        end else begin : g_no_tmo
            assign tmo_expire = 1'b0;
        end
    endgenerate

    cfp_err_counter #(
        .WIDTH (ERR_CNT_W)
    ) u_errcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (len_err | fcs_err | tmo_err),
        .count (err_count)
    );

    assign kind         = decode_kind(frame_cmd0[7:4]);
    assign frame_type   = kind;
    assign frame_subsys = decode_subsys(frame_cmd0[3:0]);
    assign type_unknown = kind == KIND_UNKNOWN;

endmodule

// File: rtl/cfp_checks.sv
module cfp_checks #(
    parameter int MAX_LEN   = 250,
    parameter int ERR_CNT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 frame_valid,
    input logic [7:0]           frame_cmd0,
    input logic [7:0]           frame_cmd1,
    input logic [7:0]           frame_len,
    input logic                 len_err,
    input logic                 fcs_err,
    input logic                 tmo_err,
    input logic [ERR_CNT_W-1:0] err_count
);

    localparam logic [ERR_CNT_W-1:0] CNT_TOP = '1;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R3

    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (32'(frame_len) <= MAX_LEN)); // R4

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({frame_valid, len_err, fcs_err, tmo_err}) <= 1); // R5

    AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> ($stable(frame_cmd0) && $stable(frame_cmd1) && $stable(frame_len))); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_err || fcs_err || tmo_err) && err_count != CNT_TOP)
        |=> err_count == ERR_CNT_W'($past(err_count) + 1'b1)); // R11

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_TOP) |=> (err_count == CNT_TOP)); // R11

    AST_TMO_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> !$past(rx_valid)); // R12

endmodule

bind cmd_frame_parser cfp_checks #(
    .MAX_LEN   (MAX_LEN),
    .ERR_CNT_W (ERR_CNT_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .frame_valid (frame_valid),
    .frame_cmd0  (frame_cmd0),
    .frame_cmd1  (frame_cmd1),
    .frame_len   (frame_len),
    .len_err     (len_err),
    .fcs_err     (fcs_err),
    .tmo_err     (tmo_err),
    .err_count   (err_count)
);

// File: tb/cmd_frame_parser_test.sv
module cmd_frame_parser_test;

    localparam int TMO  = 16;
    localparam int CNTW = 3;
    localparam int AW   = 8;

    localparam logic [1:0] K_GOOD = 2'd0;
    localparam logic [1:0] K_LEN  = 2'd1;
    localparam logic [1:0] K_FCS  = 2'd2;
    localparam logic [1:0] K_TMO  = 2'd3;

    typedef struct packed {
        logic [1:0] kind;
        logic [7:0] c0;
        logic [7:0] c1;
        logic [7:0] len;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_data = 8'h00;
    logic            frame_valid;
    logic [7:0]      frame_cmd0, frame_cmd1, frame_len;
    logic [1:0]      frame_type;
    logic [2:0]      frame_subsys;
    logic            type_unknown;
    logic [AW-1:0]   rd_addr = '0;
    logic [7:0]      rd_data;
    logic            len_err, fcs_err, tmo_err;
    logic [CNTW-1:0] err_count;

    exp_t       exp_q[$];
    logic [7:0] byte_q[$];
    logic [7:0] pl[256];
    bit         mon_busy = 1'b0;
    int         n_chk = 0;
    int         n_fail = 0;
    int         exp_err = 0;

    always #5 clk = ~clk;

    cmd_frame_parser #(
        .TIMEOUT_CYC (TMO),
        .ERR_CNT_W   (CNTW)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .frame_valid  (frame_valid),
        .frame_cmd0   (frame_cmd0),
        .frame_cmd1   (frame_cmd1),
        .frame_len    (frame_len),
        .frame_type   (frame_type),
        .frame_subsys (frame_subsys),
        .type_unknown (type_unknown),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .len_err      (len_err),
        .fcs_err      (fcs_err),
        .tmo_err      (tmo_err),
        .err_count    (err_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_type(input logic [7:0] c0);
        case (c0[7:4])
            4'h2:    return 2'd1;
            4'h4:    return 2'd2;
            4'h6:    return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [2:0] exp_sub(input logic [7:0] c0);
        case (c0[3:0])
            4'h1:    return 3'd1;
            4'h4:    return 3'd2;
            4'h5:    return 3'd3;
            4'hF:    return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    task automatic wait_done();
        idle(1);
        repeat (3) @(posedge clk);
        wait (exp_q.size() == 0 && !mon_busy);
        @(negedge clk);
    endtask

    task automatic push_err(input logic [1:0] k);
        exp_t e;
        e.kind = k; e.c0 = '0; e.c1 = '0; e.len = '0;
        exp_q.push_back(e);
    endtask

    task automatic send_frame(input logic [7:0] c0, input logic [7:0] c1,
                              input logic [7:0] len, input bit bad, input int gap);
        logic [7:0] x;
        exp_t e;
        put(8'hFE);
        put(len);  x = len;
        put(c0);   x ^= c0;
        put(c1);   x ^= c1;
        for (int i = 0; i < int'(len); i++) begin
            put(pl[i]);
            x ^= pl[i];
            if (gap > 0) idle(gap);
        end
        if (bad) begin
            push_err(K_FCS);
        end else begin
            e.kind = K_GOOD; e.c0 = c0; e.c1 = c1; e.len = len;
            exp_q.push_back(e);
            for (int i = 0; i < int'(len); i++) byte_q.push_back(pl[i]);
        end
        put(bad ? (x ^ 8'h5A) : x);
        wait_done();
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (frame_valid || len_err || fcs_err || tmo_err) begin
                logic [1:0] got;
                exp_t e;
                mon_busy = 1'b1;
                got = frame_valid ? K_GOOD : len_err ? K_LEN : fcs_err ? K_FCS : K_TMO;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected outcome", int'(got), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(got == e.kind, "R5 outcome kind", int'(got), int'(e.kind));
                    if (e.kind == K_GOOD && got == K_GOOD) begin
                        chk(frame_cmd0 == e.c0, "R2 cmd0", frame_cmd0, e.c0);
                        chk(frame_cmd1 == e.c1, "R9 cmd1", frame_cmd1, e.c1);
                        chk(frame_len == e.len, "R2 len", frame_len, e.len);
                        chk(frame_type == exp_type(e.c0), "R6 type", frame_type, exp_type(e.c0));
                        chk(frame_subsys == exp_sub(e.c0), "R7 subsys", frame_subsys, exp_sub(e.c0));
                        chk(type_unknown == (exp_type(e.c0) == 2'd0), "R8 unknown flag",
                            type_unknown, exp_type(e.c0) == 2'd0);
                        for (int i = 0; i < int'(e.len); i++) begin
                            logic [7:0] b;
                            rd_addr = AW'(i);
                            #1;
                            b = byte_q.pop_front();
                            chk(rd_data == b, "R10 payload byte", rd_data, b);
                        end
                    end else if (got != K_GOOD) begin
                        exp_err = (exp_err < 7) ? exp_err + 1 : 7;
                        @(negedge clk);
                        chk(int'(err_count) == exp_err, "R11 error count", err_count, exp_err);
                    end
                end
                mon_busy = 1'b0;
            end
        end
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(frame_valid == 1'b0, "R13 frame_valid", frame_valid, 0);
        chk({len_err, fcs_err, tmo_err} == 3'b000, "R13 error pulses",
            {len_err, fcs_err, tmo_err}, 0);
        chk(err_count == '0, "R13 err_count", err_count, 0);

        // R1 garbage before a start byte
        put(8'h01); put(8'h22); put(8'h33); put(8'hFD);
        wait_done();
        chk(err_count == '0, "R1 garbage ignored", err_count, 0);

        // R2 R7 R10 zero-length synchronous request to system
        send_frame(8'h21, 8'h01, 8'd0, 1'b0, 0);

        // R6 asynchronous message to application framework with payload
        for (int i = 0; i < 5; i++) pl[i] = 8'(8'h10 + i * 7);
        send_frame(8'h44, 8'h80, 8'd5, 1'b0, 0);

        // R9 start byte as data in command and payload positions
        pl[0] = 8'hFE; pl[1] = 8'h00; pl[2] = 8'hFE;
        send_frame(8'h65, 8'hFE, 8'd3, 1'b0, 0);

        // R4 boundary length accepted
        for (int i = 0; i < 250; i++) pl[i] = 8'(i * 13 + 1);
        send_frame(8'h2F, 8'h05, 8'd250, 1'b0, 0);

        // R8 unknown class still delivered
        pl[0] = 8'hAA; pl[1] = 8'h55;
        send_frame(8'h83, 8'h11, 8'd2, 1'b0, 0);

        // R7 other subsystem
        pl[0] = 8'h42;
        send_frame(8'h43, 8'h02, 8'd1, 1'b0, 0);

        // R4 over-long length, trailing junk ignored
        push_err(K_LEN);
        put(8'hFE); put(8'd251); put(8'h21); put(8'h01); put(8'h00);
        wait_done();

        // R4 start byte as length is over-long
        push_err(K_LEN);
        put(8'hFE); put(8'hFE); put(8'h10);
        wait_done();

        // R5 check-byte mismatch
        pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03;
        send_frame(8'h21, 8'h02, 8'd3, 1'b1, 0);

        // R12 stalled partial frame
        push_err(K_TMO);
        put(8'hFE); put(8'd4); put(8'h21);
        idle(TMO + 4);
        wait_done();

        // R12 gaps shorter than the timeout
        pl[0] = 8'h91; pl[1] = 8'h92;
        send_frame(8'h45, 8'hC0, 8'd2, 1'b0, TMO - 6);

        // R11 saturation
        for (int k = 0; k < 5; k++) begin
            pl[0] = 8'(k);
            send_frame(8'h24, 8'h00, 8'd1, 1'b1, 0);
        end
        chk(int'(err_count) == 7, "R11 saturated", err_count, 7);

        // R2 delivery still works after errors
        pl[0] = 8'h77;
        send_frame(8'h61, 8'h04, 8'd1, 1'b0, 0);

        finish_up();
    end

endmodule